// File: doc/BRIEF.md
# Sprite Zero Overlap Flag

This block watches two pixel streams while a picture is drawn: the 2-bit pattern index from the background pipeline and the 2-bit pattern index from the first sprite output unit. The first sprite output unit always carries sprite zero when that sprite is present on the line. The block raises a status flag at the first pixel in a frame where sprite zero and the background are both opaque at the same spot. Software polls the flag to learn how far drawing has gone. The flag stays set until the start of the next pre-render line.

A "present on next line" indication comes from sprite evaluation. Evaluation for the next line runs while the current line is still being drawn. For that reason the block copies the indication into its own current-line flag only on a line-start strobe. Detection is then suppressed in four cases: when either render layer is disabled, in the eight leftmost columns while either left-column show bit is clear, at the last column of the line, and once the flag is already set. Palette contents, colours and sprite priority take no part in detection.

Top module: `spr0_hit_detect`

## Requirements
- R1: With the current-line sprite-zero flag set, both layers enabled, background and sprite indices both nonzero, and x between 8 and 254, `hit` is 1 in the cycle after that pixel is presented.
- R2: Index value 2'b00 on either stream means transparent, so no hit is raised. Every other value (01, 10, 11) is opaque and qualifies.
- R3: When `bg_enable` or `spr_enable` is 0, no pixel raises `hit`.
- R4: For x from 0 to 7, no hit is raised unless both `bg_left_show` and `spr_left_show` are 1. When both are 1, those columns qualify like any other column.
- R5: A pixel at x = 255 never raises `hit`.
- R6: Once set, `hit` stays 1 through later pixels and line starts. It becomes 0 in the cycle after `prerender_dot1` is high. If a clear and a qualifying pixel arrive in the same cycle, the clear wins.
- R7: The current-line sprite-zero flag takes the value of `spr0_next_line` only on a cycle with `line_start` high. Changes to `spr0_next_line` at other times have no effect on detection for the current line.
- R8: `status_byte` carries `hit` in bit 6. All other bits are 0.
- R9: While `rst` is high and in the cycle after it, `hit` is 0 and the current-line flag is clear.
- R10: `hit` is a registered output. It is still 0 during the cycle in which the first qualifying pixel is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bg_idx | input | 2 | Background pattern index for this pixel |
| spr_idx | input | 2 | Pattern index from sprite output unit 0 |
| pix_x | input | 8 | Current pixel column |
| bg_enable | input | 1 | Background layer enabled |
| spr_enable | input | 1 | Sprite layer enabled |
| bg_left_show | input | 1 | 1 = background shown in columns 0-7 |
| spr_left_show | input | 1 | 1 = sprites shown in columns 0-7 |
| spr0_next_line | input | 1 | Sprite zero found for the next line |
| line_start | input | 1 | Strobe at the start of a line |
| prerender_dot1 | input | 1 | Strobe at dot 1 of the pre-render line |
| hit | output | 1 | Sticky overlap flag |
| status_byte | output | 8 | Status read value, flag at bit 6 |

## Verification
On every cycle, the assertions check three things: that any rise of `hit` follows a pixel that was opaque on both streams, with both layers enabled, outside the clipped columns and not at the last column; that the flag holds until a clear and drops right after one; and that the current-line flag loads only from a line-start strobe. Only the bench scenarios can show the positive cases. These are that a qualifying pixel really does set the flag, that the left columns qualify once both show bits are set, that the clear beats a simultaneous set, and that the output lags the pixel by exactly one cycle.

// File: rtl/s0h_pkg.sv
package s0h_pkg;
  typedef struct packed {
    logic bg_on;
    logic spr_on;
    logic bg_left;
    logic spr_left;
  } render_ctl_t;
endpackage

// File: rtl/s0h_line_flag.sv
module s0h_line_flag (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic next_flag,
  output logic cur_flag
);
  always_ff @(posedge clk) begin
    if (rst)             cur_flag <= 1'b0;
    else if (line_start) cur_flag <= next_flag;
  end

  // R7: the current-line copy is taken only at line start
  a_r7_load_at_start: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (cur_flag == $past(next_flag)));
  a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(cur_flag));
endmodule

// File: rtl/s0h_pixel_qual.sv
module s0h_pixel_qual
  import s0h_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int X_W       = 8,
  parameter int CLIP_COLS = 8
) (
  input  logic [IDX_W-1:0] bg_idx,
  input  logic [IDX_W-1:0] spr_idx,
  input  logic [X_W-1:0]   pix_x,
  input  render_ctl_t      ctl,
  input  logic             spr0_here,
  output logic             qualify
);
  localparam logic [X_W-1:0] CLIP_X = X_W'(CLIP_COLS);
  localparam logic [X_W-1:0] LAST_X = '1;

  logic bg_opaque, spr_opaque, in_clip, clip_block, at_last;

  always_comb begin
    bg_opaque  = |bg_idx;
    spr_opaque = |spr_idx;
    in_clip    = (pix_x < CLIP_X);
    clip_block = in_clip && !(ctl.bg_left && ctl.spr_left);
    at_last    = (pix_x == LAST_X);
    qualify    = spr0_here && bg_opaque && spr_opaque &&
                 ctl.bg_on && ctl.spr_on && !clip_block && !at_last;
  end
endmodule

// File: rtl/s0h_sticky_flag.sv
module s0h_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || clear) flag <= 1'b0;
    else if (set)     flag <= 1'b1;
  end

  // R6: sticky until cleared, clear has priority
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clear) |=> flag);
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> !flag);
endmodule

// File: rtl/spr0_hit_detect.sv
module spr0_hit_detect
  import s0h_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int X_W       = 8,
  parameter int CLIP_COLS = 8,
  parameter int STATUS_W  = 8,
  parameter int HIT_POS   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    bg_idx,
  input  logic [IDX_W-1:0]    spr_idx,
  input  logic [X_W-1:0]      pix_x,
  input  logic                bg_enable,
  input  logic                spr_enable,
  input  logic                bg_left_show,
  input  logic                spr_left_show,
  input  logic                spr0_next_line,
  input  logic                line_start,
  input  logic                prerender_dot1,
  output logic                hit,
  output logic [STATUS_W-1:0] status_byte
);
  localparam logic [X_W-1:0] LAST_X = '1;
  localparam logic [X_W-1:0] CLIP_X = X_W'(CLIP_COLS);

  render_ctl_t ctl;
  logic        spr0_cur;
  logic        qualify;

  assign ctl = '{bg_on: bg_enable, spr_on: spr_enable,
                 bg_left: bg_left_show, spr_left: spr_left_show};

  s0h_line_flag u_line (
    .clk(clk), .rst(rst), .line_start(line_start),
    .next_flag(spr0_next_line), .cur_flag(spr0_cur)
  );

  s0h_pixel_qual #(.IDX_W(IDX_W), .X_W(X_W), .CLIP_COLS(CLIP_COLS)) u_qual (
    .bg_idx(bg_idx), .spr_idx(spr_idx), .pix_x(pix_x), .ctl(ctl),
    .spr0_here(spr0_cur), .qualify(qualify)
  );

  s0h_sticky_flag u_flag (
    .clk(clk), .rst(rst), .clear(prerender_dot1), .set(qualify), .flag(hit)
  );

  always_comb begin
    status_byte          = '0;
    status_byte[HIT_POS] = hit;
  end

  // R2: a rise of the flag follows a pixel opaque on both streams
  a_r2_opaque: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(bg_idx) != '0 && $past(spr_idx) != '0));
  // R3: both layers were enabled
  a_r3_enables: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(bg_enable && spr_enable));
  // R4: left columns only with both show bits set
  a_r4_clip: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(pix_x) >= CLIP_X || $past(bg_left_show && spr_left_show)));
  // R5: never from the last column
  a_r5_last_col: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(pix_x) != LAST_X));
  // R9: clear in the cycle after reset
  a_r9_reset: assert property (@(posedge clk)
    $past(rst) |-> !hit);
endmodule

// File: tb/test_spr0_hit_detect.sv
module test_spr0_hit_detect;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bg_idx, spr_idx;
  logic [7:0] pix_x;
  logic       bg_enable, spr_enable, bg_left_show, spr_left_show;
  logic       spr0_next_line, line_start, prerender_dot1;
  logic       hit;
  logic [7:0] status_byte;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spr0_hit_detect i_spr0_hit_detect (
    .clk(clk), .rst(rst), .bg_idx(bg_idx), .spr_idx(spr_idx), .pix_x(pix_x),
    .bg_enable(bg_enable), .spr_enable(spr_enable),
    .bg_left_show(bg_left_show), .spr_left_show(spr_left_show),
    .spr0_next_line(spr0_next_line), .line_start(line_start),
    .prerender_dot1(prerender_dot1), .hit(hit), .status_byte(status_byte)
  );

  // fields: bg, spr, x, bg_en, spr_en, bg_left, spr_left, spr0, expected hit
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 2'd1, 8'd100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R1
    {2'd2, 2'd3, 8'd8,   1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R1 first unclipped col
    {2'd3, 2'd2, 8'd254, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R1 col 254
    {2'd0, 2'd1, 8'd50,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 bg clear
    {2'd2, 2'd0, 8'd50,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 spr clear
    {2'd1, 2'd1, 8'd50,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 no sprite zero
    {2'd1, 2'd1, 8'd50,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 bg off
    {2'd1, 2'd1, 8'd50,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 spr off
    {2'd1, 2'd1, 8'd0,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 bg clip
    {2'd1, 2'd1, 8'd7,   1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 spr clip
    {2'd1, 2'd1, 8'd0,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 both show
    {2'd3, 2'd3, 8'd7,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 both show col 7
    {2'd1, 2'd1, 8'd255, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R5
    {2'd3, 2'd3, 8'd255, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}  // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bg_idx = 0; spr_idx = 0; pix_x = 8'd128;
    line_start = 0; prerender_dot1 = 0;
  endtask

  task automatic clear_frame();
    @(negedge clk); idle_inputs(); prerender_dot1 = 1;
    @(negedge clk); prerender_dot1 = 0;
  endtask

  task automatic load_line(input logic s0);
    @(negedge clk); idle_inputs(); spr0_next_line = s0; line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic pixel(input logic [1:0] b, input logic [1:0] s, input logic [7:0] x);
    @(negedge clk); bg_idx = b; spr_idx = s; pix_x = x;
    @(negedge clk); idle_inputs();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    bg_enable = 1; spr_enable = 1; bg_left_show = 1; spr_left_show = 1;
    spr0_next_line = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    check("R9 reset hit", {7'd0, hit}, 8'd0);
    rst = 0;
    @(negedge clk);
    check("R9 after reset", {7'd0, hit}, 8'd0);
    check("R8 status idle", status_byte, 8'h00);

    // R9: current-line flag cleared by reset, so an opaque pixel does not hit
    pixel(2'd1, 2'd1, 8'd60);
    check("R9 line flag reset", {7'd0, hit}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      clear_frame();
      load_line(v[1]);
      bg_enable = v[5]; spr_enable = v[4];
      bg_left_show = v[3]; spr_left_show = v[2];
      pixel(v[17:16], v[15:14], v[13:6]);
      check($sformatf("R1/R2/R3/R4/R5 vector %0d", i), {7'd0, hit}, {7'd0, v[0]});
    end
    bg_enable = 1; spr_enable = 1; bg_left_show = 1; spr_left_show = 1;

    // R10: registered output timing
    clear_frame();
    load_line(1);
    @(negedge clk); bg_idx = 2'd1; spr_idx = 2'd2; pix_x = 8'd30;
    #1 check("R10 same cycle", {7'd0, hit}, 8'd0);
    @(negedge clk); idle_inputs();
    check("R10 next cycle", {7'd0, hit}, 8'd1);
    check("R8 status set", status_byte, 8'h40);

    // R6: sticky through transparent pixels, last column and a new line
    pixel(2'd0, 2'd0, 8'd31);
    pixel(2'd1, 2'd1, 8'd255);
    load_line(0);
    pixel(2'd0, 2'd3, 8'd40);
    check("R6 sticky", {7'd0, hit}, 8'd1);
    clear_frame();
    check("R6 cleared", {7'd0, hit}, 8'd0);
    check("R8 status cleared", status_byte, 8'h00);

    // R6: clear wins over a simultaneous qualifying pixel
    load_line(1);
    @(negedge clk); bg_idx = 2'd3; spr_idx = 2'd3; pix_x = 8'd90; prerender_dot1 = 1;
    @(negedge clk); idle_inputs();
    check("R6 clear priority", {7'd0, hit}, 8'd0);

    // R7: next-line flag changes outside line start have no effect
    clear_frame();
    load_line(1);
    @(negedge clk); spr0_next_line = 0;
    pixel(2'd2, 2'd2, 8'd70);
    check("R7 keep current set", {7'd0, hit}, 8'd1);
    clear_frame();
    load_line(0);
    @(negedge clk); spr0_next_line = 1;
    pixel(2'd2, 2'd2, 8'd70);
    check("R7 keep current clear", {7'd0, hit}, 8'd0);
    load_line(1);
    pixel(2'd2, 2'd2, 8'd70);
    check("R7 loaded at line start", {7'd0, hit}, 8'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule